// File: doc/BRIEF.md
# Two-Bank Interleaved Read Controller

This controller serves word reads from two identical memory banks that share a single request stream. Word addresses with bit 0 clear go to the even bank (bank 0) and those with bit 0 set go to the odd bank (bank 1). Each bank sees the word address shifted right by one. Every bank has a fixed access latency and then a precharge interval before it can be started again. The controller lets one bank run its setup and access while the other bank returns data. A sequential stream therefore gets two results in back-to-back cycles per bank cycle, instead of one result per full access-plus-precharge time.

Requests arrive on a valid/ready handshake. Each accepted request produces a one-cycle strobe and a bank address on the selected bank's port. The returned word comes out of the controller one register later, tagged with the word address that was requested, and results leave strictly in acceptance order. When only one bank is fitted, the `cfg_single` input turns interleaving off. Every access then goes to bank 0 with the unshifted address and pays the full bank cycle.

Top module: `ilv_read_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller clears `out_valid` and both bank strobes, and it leaves `req_ready` high after that edge.
- R2: With `cfg_single`=0, a request whose address has bit 0 clear goes to bank 0 and one with bit 0 set goes to bank 1. The bank address is `req_addr >> 1`. The strobe is high for exactly the one cycle that follows the accepting edge.
- R3: A result appears on `out_valid` LAT+1 cycles after the accepting edge. `out_addr` carries the requested word address and `out_data` carries the word that the bank returned.
- R4: Results leave in acceptance order, at most one per cycle. The two banks never strobe or return data in the same cycle.
- R5: Two sequential addresses that target different idle banks are accepted on consecutive edges, and their results appear on consecutive cycles.
- R6: A bank is never strobed again sooner than LAT+PRE cycles after its previous strobe. A request that is held waiting for that bank is accepted exactly LAT+PRE edges after the bank's previous acceptance.
- R7: `req_ready` is low while the target bank is inside its LAT+PRE window, and high otherwise, regardless of the state of the other bank.
- R8: With `cfg_single`=1, every request goes to bank 0 with the unshifted address, and bank 1 is never strobed.
- R9: A cycle without a handshake (`req_valid` low, or `req_ready` low) produces no bank strobe and, LAT+1 cycles later, no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_single | input | 1 | 1 = only bank 0 fitted, interleaving off |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Requested word address |
| req_ready | output | 1 | Target bank can start this cycle |
| bank0_stb | output | 1 | Start pulse to the even bank |
| bank0_addr | output | ADDR_W | Address to the even bank |
| bank0_rvalid | input | 1 | Even bank data valid |
| bank0_rdata | input | DATA_W | Even bank read data |
| bank1_stb | output | 1 | Start pulse to the odd bank |
| bank1_addr | output | ADDR_W | Address to the odd bank |
| bank1_rvalid | input | 1 | Odd bank data valid |
| bank1_rdata | input | DATA_W | Odd bank read data |
| out_valid | output | 1 | Result valid |
| out_addr | output | ADDR_W | Word address of the result |
| out_data | output | DATA_W | Result data |

## Verification
The assertions check the following on every cycle:
- each bank's minimum strobe spacing;
- the mutual exclusion of strobes and of returns;
- the one-register path from a bank return to `out_valid`;
- the absence of a strobe without a handshake;
- the routing to bank 0 in single-bank mode.

The bench scenarios cover the behaviour that needs a model of the request stream. They show that the returned data and tags match the requested addresses and that results leave in order. They also show that the exact edge on which a held request is accepted matches the precharge rule, that a sequential pair overlaps into back-to-back results, and that `req_ready` for one bank is unaffected by the other.

// File: rtl/ilv_pkg.sv
// Shared bank-select type and helper for the interleaved read controller.
// Assumes exactly two banks, selected by word-address bit 0.
package ilv_pkg;

    typedef enum logic {
        BANK_EVEN = 1'b0,
        BANK_ODD  = 1'b1
    } bank_e;

    // Picks the target bank; single-bank mode always picks the even bank.
    function automatic bank_e pick_bank(input logic single, input logic lsb);
        return (single || !lsb) ? BANK_EVEN : BANK_ODD;
    endfunction

endpackage

// File: rtl/ilv_bank_slot.sv
// One bank's issue slot: registers the strobe, the bank address and the
// request tag, and holds the bank busy for GAP cycles from a start.
// Assumes GAP >= 2 and that start is only raised while busy is low.
module ilv_bank_slot #(
    parameter int ADDR_W = 16,
    parameter int GAP    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_baddr,
    input  logic [ADDR_W-1:0] start_tag,
    output logic              busy,
    output logic              stb,
    output logic [ADDR_W-1:0] baddr,
    output logic [ADDR_W-1:0] tag
);
    localparam int CNT_W = $clog2(GAP + 1);

    logic [CNT_W-1:0] hold_cnt;

    // Counts down the access-plus-precharge window after each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (start) begin
            hold_cnt <= CNT_W'(GAP - 1);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // Issues a one-cycle strobe for each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb <= 1'b0;
        end else begin
            stb <= start;
        end
    end

    // Captures the bank address and the tag of the started request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baddr <= '0;
            tag   <= '0;
        end else if (start) begin
            baddr <= start_baddr;
            tag   <= start_tag;
        end
    end

    assign busy = (hold_cnt != '0);

endmodule

// File: rtl/ilv_return_merge.sv
// Merges bank returns into one registered result stream with its tag.
// Assumes at most one bank returns in any cycle (a single issue per cycle
// plus equal bank latencies keeps returns apart and in order).
module ilv_return_merge #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int NB     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NB-1:0]               rvalid,
    input  logic [NB-1:0][DATA_W-1:0]   rdata,
    input  logic [NB-1:0][ADDR_W-1:0]   rtag,
    output logic                        out_valid,
    output logic [ADDR_W-1:0]           out_addr,
    output logic [DATA_W-1:0]           out_data
);
    logic              any_v;
    logic [DATA_W-1:0] sel_data;
    logic [ADDR_W-1:0] sel_tag;

    // Selects the returning bank's data and tag.
    always_comb begin
        any_v    = 1'b0;
        sel_data = '0;
        sel_tag  = '0;
        for (int b = 0; b < NB; b++) begin
            if (rvalid[b] && !any_v) begin
                any_v    = 1'b1;
                sel_data = rdata[b];
                sel_tag  = rtag[b];
            end
        end
    end

    // Registers the selected result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= any_v;
            if (any_v) begin
                out_addr <= sel_tag;
                out_data <= sel_data;
            end
        end
    end

endmodule

// File: rtl/ilv_read_ctrl.sv
// Two-bank interleaved read controller. Even word addresses go to bank 0 and
// odd ones to bank 1, so that one bank's setup overlaps the other's return.
// cfg_single routes every access to bank 0 with the full address.
// Assumes banks return data exactly LAT cycles after they sample a strobe
// and need PRE further cycles before they can be started again. cfg_single
// is changed only between requests.
module ilv_read_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LAT    = 5,
    parameter int PRE    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_single,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              bank0_stb,
    output logic [ADDR_W-1:0] bank0_addr,
    input  logic              bank0_rvalid,
    input  logic [DATA_W-1:0] bank0_rdata,
    output logic              bank1_stb,
    output logic [ADDR_W-1:0] bank1_addr,
    input  logic              bank1_rvalid,
    input  logic [DATA_W-1:0] bank1_rdata,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    import ilv_pkg::*;

    localparam int NB  = 2;
    localparam int GAP = LAT + PRE;

    logic                      tgt;
    logic                      accept;
    logic [ADDR_W-1:0]         start_baddr;
    logic [NB-1:0]             busy;
    logic [NB-1:0]             start;
    logic [NB-1:0]             stb;
    logic [NB-1:0][ADDR_W-1:0] baddr;
    logic [NB-1:0][ADDR_W-1:0] tag;
    logic [NB-1:0]             rvalid;
    logic [NB-1:0][DATA_W-1:0] rdata;

    // Decodes the target bank and the bank-local address of the request.
    always_comb begin
        tgt         = pick_bank(cfg_single, req_addr[0]);
        start_baddr = cfg_single ? req_addr : {1'b0, req_addr[ADDR_W-1:1]};
    end

    assign req_ready = !busy[tgt];
    assign accept    = req_valid && req_ready;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        assign start[g] = accept && (tgt == 1'(g));

        ilv_bank_slot #(
            .ADDR_W (ADDR_W),
            .GAP    (GAP)
        ) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .start       (start[g]),
            .start_baddr (start_baddr),
            .start_tag   (req_addr),
            .busy        (busy[g]),
            .stb         (stb[g]),
            .baddr       (baddr[g]),
            .tag         (tag[g])
        );
    end

    assign bank0_stb  = stb[0];
    assign bank0_addr = baddr[0];
    assign bank1_stb  = stb[1];
    assign bank1_addr = baddr[1];
    assign rvalid     = {bank1_rvalid, bank0_rvalid};
    assign rdata      = {bank1_rdata, bank0_rdata};

    ilv_return_merge #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NB     (NB)
    ) merge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rvalid    (rvalid),
        .rdata     (rdata),
        .rtag      (tag),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_data  (out_data)
    );

endmodule

// File: rtl/ilv_read_ctrl_checker.sv
// Protocol checker for ilv_read_ctrl, attached to every instance by bind.
// Assumes banks honour the fixed-latency contract described at the top.
module ilv_read_ctrl_checker #(
    parameter int LAT = 5,
    parameter int PRE = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_single,
    input logic req_valid,
    input logic req_ready,
    input logic bank0_stb,
    input logic bank1_stb,
    input logic bank0_rvalid,
    input logic bank1_rvalid,
    input logic out_valid
);
    localparam int GAP = LAT + PRE;
    localparam int W   = $clog2(GAP + 1);

    logic [W-1:0] since0, since1;
    logic         seen0, seen1;

    // Measures the cycles since each bank's last strobe (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since0 <= '0;
            since1 <= '0;
            seen0  <= 1'b0;
            seen1  <= 1'b0;
        end else begin
            if (bank0_stb) begin
                since0 <= '0;
                seen0  <= 1'b1;
            end else if (since0 != W'(GAP)) begin
                since0 <= since0 + 1'b1;
            end
            if (bank1_stb) begin
                since1 <= '0;
                seen1  <= 1'b1;
            end else if (since1 != W'(GAP)) begin
                since1 <= since1 + 1'b1;
            end
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !bank0_stb && !bank1_stb && req_ready));

    assert_return_to_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bank0_rvalid || bank1_rvalid) |=> out_valid);

    assert_no_spurious_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank0_rvalid || bank1_rvalid) |=> !out_valid);

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank0_stb && bank1_stb));

    assert_one_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank0_rvalid && bank1_rvalid));

    assert_bank0_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank0_stb && seen0) |-> (since0 >= W'(GAP - 1)));

    assert_bank1_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank1_stb && seen1) |-> (since1 >= W'(GAP - 1)));

    assert_single_routes_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_single && req_valid && req_ready) |=> (bank0_stb && !bank1_stb));

    assert_no_handshake_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !(bank0_stb || bank1_stb));

endmodule

bind ilv_read_ctrl ilv_read_ctrl_checker #(
    .LAT (LAT),
    .PRE (PRE)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_single   (cfg_single),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .bank0_stb    (bank0_stb),
    .bank1_stb    (bank1_stb),
    .bank0_rvalid (bank0_rvalid),
    .bank1_rvalid (bank1_rvalid),
    .out_valid    (out_valid)
);

// File: tb/ilv_read_ctrl_tb_top.sv
`timescale 1ns/1ps

// Fixed-latency bank model: data valid LAT cycles after a sampled strobe.
// Data word = {bank id, 8'h5A, bank address}.
module ilv_tb_bank #(
    parameter int LAT = 5,
    parameter int ID  = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stb,
    input  logic [15:0] addr,
    output logic        rvalid,
    output logic [31:0] rdata
);
    logic [LAT-1:0] vpipe;
    logic [15:0]    apipe [LAT];

    // Delays strobe and address through the access latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpipe <= '0;
            for (int i = 0; i < LAT; i++) apipe[i] <= '0;
        end else begin
            vpipe[0] <= stb;
            apipe[0] <= addr;
            for (int i = 1; i < LAT; i++) begin
                vpipe[i] <= vpipe[i-1];
                apipe[i] <= apipe[i-1];
            end
        end
    end

    assign rvalid = vpipe[LAT-1];
    assign rdata  = {8'(ID), 8'h5A, apipe[LAT-1]};
endmodule

module ilv_read_ctrl_tb_top;
    localparam int LAT = 5;
    localparam int PRE = 2;
    localparam int GAP = LAT + PRE;

    typedef struct packed {
        logic        single;
        logic [15:0] addr;
        logic        exp_bank;
        logic [3:0]  exp_gap;   // edges after previous accept, 0 = unchecked
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h0000, 1'b0, 4'd0},
        '{1'b0, 16'h0001, 1'b1, 4'd1},
        '{1'b0, 16'h0002, 1'b0, 4'd6},
        '{1'b0, 16'h0003, 1'b1, 4'd1},
        '{1'b0, 16'h0010, 1'b0, 4'd6},
        '{1'b0, 16'h0012, 1'b0, 4'd7},
        '{1'b0, 16'h0013, 1'b1, 4'd1},
        '{1'b0, 16'h0025, 1'b1, 4'd7},
        '{1'b0, 16'h0024, 1'b0, 4'd1},
        '{1'b1, 16'h0031, 1'b0, 4'd7},
        '{1'b1, 16'h0032, 1'b0, 4'd7},
        '{1'b1, 16'h0033, 1'b0, 4'd7},
        '{1'b0, 16'h0041, 1'b1, 4'd1},
        '{1'b0, 16'h0040, 1'b0, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_single = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic        bank0_stb, bank1_stb;
    logic [15:0] bank0_addr, bank1_addr;
    logic        bank0_rvalid, bank1_rvalid;
    logic [31:0] bank0_rdata, bank1_rdata;
    logic        out_valid;
    logic [15:0] out_addr;
    logic [31:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int n_stb    = 0;
    int n_out    = 0;
    bit done     = 0;

    logic [15:0] q_addr [64];
    logic [31:0] q_data [64];
    int          q_edge [64];
    int          wr = 0;
    int          rd = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ilv_read_ctrl #(
        .ADDR_W (16), .DATA_W (32), .LAT (LAT), .PRE (PRE)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_single (cfg_single),
        .req_valid (req_valid), .req_addr (req_addr), .req_ready (req_ready),
        .bank0_stb (bank0_stb), .bank0_addr (bank0_addr),
        .bank0_rvalid (bank0_rvalid), .bank0_rdata (bank0_rdata),
        .bank1_stb (bank1_stb), .bank1_addr (bank1_addr),
        .bank1_rvalid (bank1_rvalid), .bank1_rdata (bank1_rdata),
        .out_valid (out_valid), .out_addr (out_addr), .out_data (out_data)
    );

    ilv_tb_bank #(.LAT (LAT), .ID (0)) bank0_i (
        .clk (clk), .rst_n (rst_n), .stb (bank0_stb), .addr (bank0_addr),
        .rvalid (bank0_rvalid), .rdata (bank0_rdata));
    ilv_tb_bank #(.LAT (LAT), .ID (1)) bank1_i (
        .clk (clk), .rst_n (rst_n), .stb (bank1_stb), .addr (bank1_addr),
        .rvalid (bank1_rvalid), .rdata (bank1_rdata));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Result monitor: in-order tag, data and timing (R3, R4).
    always @(negedge clk) begin
        if (rst_n && (bank0_stb || bank1_stb)) n_stb++;
        if (rst_n && out_valid) begin
            n_out++;
            if (rd == wr) begin
                check(0, "R9", "unexpected result", out_addr, 0);
            end else begin
                check(out_addr == q_addr[rd], "R4", "result order/tag", out_addr, q_addr[rd]);
                check(out_data == q_data[rd], "R3", "result data", out_data, q_data[rd]);
                check(cyc == q_edge[rd], "R3", "result cycle", cyc, q_edge[rd]);
                rd++;
            end
        end
    end

    // Drives one request, waits for acceptance, checks the strobe.
    task automatic send(input logic single, input logic [15:0] addr, output int acc);
        logic        bsel;
        logic [15:0] baddr;
        bsel  = single ? 1'b0 : addr[0];
        baddr = single ? addr : {1'b0, addr[15:1]};
        cfg_single = single;
        req_addr   = addr;
        req_valid  = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc + 1;
        q_addr[wr] = addr;
        q_data[wr] = {7'd0, bsel, 8'h5A, baddr};
        q_edge[wr] = acc + LAT + 1;
        wr++;
        @(negedge clk);
        req_valid = 1'b0;
        if (single)
            check(bank0_stb && !bank1_stb, "R8", "single-mode strobe", {bank1_stb, bank0_stb}, 2'b01);
        else
            check(bsel ? (bank1_stb && !bank0_stb) : (bank0_stb && !bank1_stb),
                  "R2", "bank strobe", {bank1_stb, bank0_stb}, bsel ? 2'b10 : 2'b01);
        check((bsel ? bank1_addr : bank0_addr) == baddr, single ? "R8" : "R2", "bank address",
              bsel ? bank1_addr : bank0_addr, baddr);
    endtask

    task automatic drain();
        int t = 0;
        while (rd != wr && t < 100) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int prev_acc;
        int acc;
        int s0;
        int o0;
        prev_acc = 0;
        repeat (3) @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(!bank0_stb && !bank1_stb, "R1", "strobes in reset", {bank1_stb, bank0_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk: routing, overlap and precharge spacing.
        for (int i = 0; i < NV; i++) begin
            send(VEC[i].single, VEC[i].addr, acc);
            if (VEC[i].exp_gap != 0)
                check(acc - prev_acc == int'(VEC[i].exp_gap),
                      VEC[i].exp_gap == 1 ? "R5" : "R6", "accept spacing",
                      acc - prev_acc, VEC[i].exp_gap);
            prev_acc = acc;
        end
        drain();

        // R7: ready follows the target bank only.
        send(1'b0, 16'h0050, acc);
        req_addr = 16'h0052;
        #1;
        check(req_ready == 1'b0, "R7", "ready for busy bank", req_ready, 0);
        req_addr = 16'h0053;
        #1;
        check(req_ready == 1'b1, "R7", "ready for idle bank", req_ready, 1);
        req_addr = 16'h0052;
        while (cyc < acc + GAP - 2) @(negedge clk);
        #1;
        check(req_ready == 1'b0, "R7", "ready one cycle before free", req_ready, 0);
        @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R7", "ready once free", req_ready, 1);
        drain();

        // R9: no handshake, changing address, produces nothing.
        s0 = n_stb;
        o0 = n_out;
        for (int k = 0; k < 20; k++) begin
            req_addr = 16'(k * 3);
            @(negedge clk);
        end
        check(n_stb == s0, "R9", "strobes without handshake", n_stb - s0, 0);
        check(n_out == o0, "R9", "results without handshake", n_out - o0, 0);

        // R1: reset in flight drops the pending access.
        send(1'b0, 16'h0061, acc);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd = wr;
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        o0 = n_out;
        repeat (12) @(negedge clk);
        check(n_out == o0, "R1", "no result after reset", n_out - o0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule